// File: doc/BRIEF.md
# Region XOR Checksum Checker

This block walks a byte-wide memory of up to 512 locations in a single pass. Along the way it folds three fixed address windows into running XOR sums. The byte that sits just past each window holds the expected sum for that window. When the sum and the stored byte disagree, the error flag for that window is raised. A flag stays high until software reads the status word. If a read and a new error land in the same clock, the flag stays set.

A single start strobe launches the pass. The block then reads one byte per clock through a synchronous read port and pulses a done output once the last stored sum has been compared. The status word is available at all times. It also carries the current level of an external enable pin, so one read returns both the integrity result and the state of that pin.

Top module: `xor_region_checker`

## Requirements
- R1: A start strobe sampled high while idle begins a pass. From the following cycle, `mem_ren_o` is high for exactly 256 consecutive cycles, and `mem_addr_o` steps by one per cycle from 0x007 to 0x106. The memory returns `mem_rdata_i` one clock after it samples the address.
- R2: `done_o` is high for one cycle only. It rises on the 258th rising edge, counting the edge that samples start as the first.
- R3: Window A is the XOR of bytes 0x007..0x07C, and its stored sum is at 0x07D. Only a mismatch between the two sets status bit 0.
- R4: Window B is the XOR of bytes 0x07E..0x0AC, and its stored sum is at 0x0AD. Only a mismatch sets status bit 2.
- R5: Window C is the XOR of bytes 0x0AE..0x105, and its stored sum is at 0x106. Only a mismatch sets status bit 3.
- R6: An error flag stays set through later passes that find no error, until the status word is read.
- R7: A cycle with `stat_rd_i` high presents the flags as they were before that cycle, then clears them at the clock edge.
- R8: If a window mismatch is detected at the same edge as a read, the flag for that window ends up set.
- R9: Status bit 15 shows `en_pin_i` as sampled at the previous rising edge. Bits 14:4 and bit 1 always read 0.
- R10: A start strobe that arrives during a pass is ignored. The address sequence and the timing of done are unchanged.
- R11: After reset, all flags, `done_o` and `mem_ren_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a pass (ignored while busy) |
| mem_ren_o | output | 1 | Memory read enable |
| mem_addr_o | output | 9 | Memory read address |
| mem_rdata_i | input | 8 | Read data, one clock after the address |
| stat_rd_i | input | 1 | Status read strobe; clears the flags |
| en_pin_i | input | 1 | External enable pin level |
| status_o | output | 16 | Status word: bit15 pin, bit3/2/0 window flags |
| done_o | output | 1 | One-cycle pulse at the end of a pass |

## Verification
The pass is run on an all-zero memory and on random contents with correct sums. These show that the windows produce no false flags. Single corruptions are then placed at a stored sum, at the last byte of a window and at the first byte of a window, which shows that each window maps to its own status bit and that the window edges sit where they should. Bytes just outside the windows are changed to confirm they are ignored. Two flips of the same bit inside one window must cancel, which separates an XOR check from an additive one. Timed reads during a pass test clear-on-read and the rule that a set wins over a read.

// File: rtl/xrc_pkg.sv
package xrc_pkg;
  localparam int ADDR_W  = 9;
  localparam int DATA_W  = 8;
  localparam int STAT_W  = 16;
  localparam int N_REG   = 3;
  localparam int PIN_BIT = 15;
  localparam int POS_W   = 4;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;

  typedef struct packed {
    logic  vld;
    addr_t addr;
  } tag_t;

  // window bounds, index 0 in the low slice; stored sum sits at hi+1
  localparam logic [N_REG-1:0][ADDR_W-1:0] REG_LO = {9'h0AE, 9'h07E, 9'h007};
  localparam logic [N_REG-1:0][ADDR_W-1:0] REG_HI = {9'h105, 9'h0AC, 9'h07C};
  // status bit for each window
  localparam logic [N_REG-1:0][POS_W-1:0]  FLAG_POS = {4'd3, 4'd2, 4'd0};

  localparam addr_t SCAN_FIRST = REG_LO[0];
  localparam addr_t SCAN_LAST  = addr_t'(REG_HI[N_REG-1] + 9'd1);
endpackage

// File: rtl/xrc_scan_seq.sv
module xrc_scan_seq
  import xrc_pkg::*;
#(
  parameter addr_t FIRST = SCAN_FIRST,
  parameter addr_t LAST  = SCAN_LAST
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  start_i,
  output logic  ren_o,
  output addr_t addr_o,
  output tag_t  tag_o
);
  logic  busy_q;
  addr_t addr_q;
  tag_t  tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      addr_q <= FIRST;
      tag_q  <= '0;
    end else begin
      // tag follows the address by the memory latency
      tag_q.vld  <= busy_q;
      tag_q.addr <= addr_q;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          addr_q <= FIRST;
        end
      end else if (addr_q == LAST) begin
        busy_q <= 1'b0;
      end else begin
        addr_q <= addr_t'(addr_q + 1'b1);
      end
    end
  end

  assign ren_o  = busy_q;
  assign addr_o = addr_q;
  assign tag_o  = tag_q;

  assert_addr_step_R1: assert property (@(posedge clk) disable iff (rst)
    (busy_q && addr_q != LAST) |=> (busy_q && addr_q == addr_t'($past(addr_q) + 1'b1)));

  assert_launch_R1: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && start_i) |=> (busy_q && addr_q == FIRST));

  assert_pass_ends_R10: assert property (@(posedge clk) disable iff (rst)
    (busy_q && addr_q == LAST) |=> !busy_q);
endmodule

// File: rtl/xrc_xor_lane.sv
module xrc_xor_lane
  import xrc_pkg::*;
#(
  parameter addr_t LO = 9'h007,
  parameter addr_t HI = 9'h07C
) (
  input  logic  clk,
  input  logic  rst,
  input  tag_t  tag_i,
  input  byte_t data_i,
  output logic  mismatch_o
);
  localparam addr_t CK = addr_t'(HI + 9'd1);

  byte_t acc_q;
  logic  in_rng, at_ck;

  assign in_rng = tag_i.vld && (tag_i.addr >= LO) && (tag_i.addr <= HI);
  assign at_ck  = tag_i.vld && (tag_i.addr == CK);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (in_rng) begin
      // first byte of the window restarts the sum from zero
      acc_q <= ((tag_i.addr == LO) ? byte_t'(0) : acc_q) ^ data_i;
    end
  end

  assign mismatch_o = at_ck && (acc_q != data_i);

  assert_acc_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!in_rng) |=> $stable(acc_q));
endmodule

// File: rtl/xrc_status.sv
module xrc_status
  import xrc_pkg::*;
#(
  parameter int NR = N_REG,
  parameter int SW = STAT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NR-1:0] set_i,
  input  logic          rd_i,
  input  logic          pin_i,
  output logic [SW-1:0] status_o
);
  logic [NR-1:0] flags_q;
  logic          pin_q;

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= set_i | (flags_q & {NR{~rd_i}});
  end

  always_ff @(posedge clk) pin_q <= pin_i;

  always_comb begin
    status_o          = '0;
    status_o[PIN_BIT] = pin_q;
    for (int k = 0; k < NR; k++) status_o[FLAG_POS[k]] = flags_q[k];
  end

  genvar g;
  generate
    for (g = 0; g < NR; g++) begin : g_chk
      assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        set_i[g] |=> flags_q[g]);
      assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !set_i[g]) |=> !flags_q[g]);
      assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (flags_q[g] && !rd_i) |=> flags_q[g]);
    end
  endgenerate
endmodule

// File: rtl/xor_region_checker.sv
module xor_region_checker
  import xrc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  output logic        mem_ren_o,
  output logic [8:0]  mem_addr_o,
  input  logic [7:0]  mem_rdata_i,
  input  logic        stat_rd_i,
  input  logic        en_pin_i,
  output logic [15:0] status_o,
  output logic        done_o
);
  tag_t             tag;
  logic [N_REG-1:0] mis;
  logic             done_q;

  xrc_scan_seq #(.FIRST(SCAN_FIRST), .LAST(SCAN_LAST)) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i),
    .ren_o(mem_ren_o), .addr_o(mem_addr_o), .tag_o(tag)
  );

  genvar k;
  generate
    for (k = 0; k < N_REG; k++) begin : g_lane
      xrc_xor_lane #(.LO(REG_LO[k]), .HI(REG_HI[k])) u_lane (
        .clk(clk), .rst(rst), .tag_i(tag), .data_i(mem_rdata_i),
        .mismatch_o(mis[k])
      );
    end
  endgenerate

  xrc_status #(.NR(N_REG), .SW(STAT_W)) u_stat (
    .clk(clk), .rst(rst), .set_i(mis), .rd_i(stat_rd_i),
    .pin_i(en_pin_i), .status_o(status_o)
  );

  always_ff @(posedge clk) begin
    if (rst) done_q <= 1'b0;
    else     done_q <= tag.vld && (tag.addr == SCAN_LAST);
  end
  assign done_o = done_q;

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !mem_ren_o);
  assert_pin_level_R9: assert property (@(posedge clk) disable iff (rst)
    status_o[PIN_BIT] == $past(en_pin_i));
  assert_spare_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (status_o[14:4] == '0) && !status_o[1]);
endmodule

// File: tb/xor_region_checker_bench.sv
module xor_region_checker_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        mem_ren;
  logic [8:0]  mem_addr;
  logic [7:0]  mem_rdata = 8'h00;
  logic        stat_rd = 1'b0;
  logic        en_pin = 1'b0;
  logic [15:0] status;
  logic        done;

  int n_run = 0;
  int n_fail = 0;

  logic [7:0]  mem [512];
  logic [15:0] exp_q [$];
  logic [2:0]  exp_flags = '0;

  localparam int LO [3] = '{'h007, 'h07E, 'h0AE};
  localparam int HI [3] = '{'h07C, 'h0AC, 'h105};

  xor_region_checker u_xor_region_checker (
    .clk(clk), .rst(rst), .start_i(start_i),
    .mem_ren_o(mem_ren), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .stat_rd_i(stat_rd), .en_pin_i(en_pin),
    .status_o(status), .done_o(done)
  );

  always #10 clk = ~clk;

  always @(posedge clk) if (mem_ren) mem_rdata <= mem[mem_addr];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word();
    return {en_pin, 11'b0, exp_flags[2], exp_flags[1], 1'b0, exp_flags[0]};
  endfunction

  function automatic logic [2:0] model_mism();
    logic [2:0] m;
    for (int r = 0; r < 3; r++) begin
      logic [7:0] x = 8'h00;
      for (int a = LO[r]; a <= HI[r]; a++) x ^= mem[a];
      m[r] = (x != mem[HI[r] + 1]);
    end
    return m;
  endfunction

  task automatic fill(input bit zero);
    for (int a = 0; a < 512; a++) mem[a] = zero ? 8'h00 : 8'($urandom);
    for (int r = 0; r < 3; r++) begin
      logic [7:0] x = 8'h00;
      for (int a = LO[r]; a <= HI[r]; a++) x ^= mem[a];
      mem[HI[r] + 1] = x;
    end
  endtask

  // driver: predicts the status at done, then runs one pass
  task automatic scan(input string req, input int rd_edge, input bit restart);
    bit seq_ok = 1'b1;
    bit done_ok = 1'b1;
    if (rd_edge > 0) exp_flags = '0;
    exp_flags |= model_mism();
    exp_q.push_back(exp_word());
    @(negedge clk) start_i = 1'b1;
    for (int k = 1; k <= 262; k++) begin
      @(negedge clk);
      start_i = restart && (k == 50);
      stat_rd = (rd_edge > 0) && (k == rd_edge - 1);
      if (k <= 256) begin
        if (!mem_ren || mem_addr != 9'(6 + k)) seq_ok = 1'b0;
      end else if (mem_ren) seq_ok = 1'b0;
      if (done != (k == 258)) done_ok = 1'b0;
    end
    chk({"R1 sequence ", req}, seq_ok, 1);
    chk({"R2 done timing ", req}, done_ok, 1);
    if (restart) chk("R10 start while busy", seq_ok && done_ok, 1);
  endtask

  task automatic read_status(input string req);
    @(negedge clk);
    chk({"R7 value before clear ", req}, status, exp_word());
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    exp_flags = '0;
    chk({"R7 cleared ", req}, status, exp_word());
  endtask

  // monitor: compares the status against the queue on every done
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q.size() == 0) chk("R2 unexpected done", 1, 0);
      else chk("R3/R4/R5 status at done", status, exp_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    fill(1'b1);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 status after reset", status, 16'h0000);
    chk("R11 done after reset", done, 0);
    chk("R11 ren after reset", mem_ren, 0);

    scan("zero memory", 0, 0);
    fill(1'b0);
    scan("random good", 0, 0);

    mem[9'h07D] ^= 8'h01;                 // R3: stored sum of window A
    scan("R3 sum byte", 0, 0);
    read_status("R3");

    fill(1'b0); mem[9'h0AC] ^= 8'h80;     // R4: last byte of window B
    scan("R4 last byte", 0, 0);
    read_status("R4");

    fill(1'b0); mem[9'h0AE] ^= 8'h04;     // R5: first byte of window C
    scan("R5 first byte", 0, 0);
    read_status("R5");

    fill(1'b0);                            // outside bytes must not matter
    mem[9'h006] ^= 8'hFF; mem[9'h107] ^= 8'h5A; mem[9'h1FF] ^= 8'h33;
    scan("R3 R5 outside bytes", 0, 0);
    chk("R3 R5 outside no flags", status[3:0], 4'h0);

    fill(1'b0);                            // XOR cancels paired flips
    mem[9'h080] ^= 8'h10; mem[9'h090] ^= 8'h10;
    scan("R4 paired flips", 0, 0);
    chk("R4 paired flips cancel", status[2], 0);

    fill(1'b0); mem[9'h100] ^= 8'h02;     // R6 sticky
    scan("R6 bad pass", 0, 0);
    fill(1'b0);
    scan("R6 good pass", 0, 0);
    chk("R6 flag kept", status[3], 1);
    read_status("R6");

    fill(1'b0); mem[9'h0A0] ^= 8'h08;     // set bit2 first
    scan("R8 setup", 0, 0);
    fill(1'b0); mem[9'h010] ^= 8'h20;     // window A bad, read at its compare edge
    scan("R8 set vs read", 121, 0);
    chk("R8 set wins", status[0], 1);
    chk("R7 read during pass cleared", status[2], 0);
    read_status("R8");

    en_pin = 1'b1;                         // R9
    @(negedge clk);
    chk("R9 pin high", status, 16'h8000);
    fill(1'b0);
    scan("R9 pin pass", 0, 1);             // also R10
    en_pin = 1'b0;
    @(negedge clk);
    chk("R9 pin low", status, 16'h0000);

    repeat (4) @(negedge clk);
    chk("R2 queue drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule